// File: doc/BRIEF.md
# Flash Sector Chip-Select Decoder with Write Protection

This block sits between a microcontroller's 16-bit multiplexed address/data bus and two separate flash arrays: a main array and a smaller boot array. The low address byte travels on the shared data lines. The block captures it while the address-latch strobe is high. From the full address and the active bus strobe, it raises exactly one sector select. There is one select line for each sector of each array.

Software programs every sector through a small register file. Each sector has a base address, an enable, a choice of program space or data space, and a write-protect bit.

The block also passes write strobes on to the arrays. A write that lands in a protected sector still selects its sector, but the array's write strobe stays inactive and a sticky violation flag is raised. Each array has its own write strobe, so one array can take a write while the other array is read.

Top module: `flash_sector_decoder`

## Requirements
- R1: The low address byte is captured from `ad_lo` on a rising clock edge where `ale` is high. Values driven on `ad_lo` while `ale` is low have no effect on the decode.
- R2: While `rst_n` is low, and after it is released, the state is as follows. All selects are low. Both array write strobes are high. The violation flag is 0. Every sector register reads 0x0004 (unmapped, data space, write-protected, base 0). The status register reads 0.
- R3: Each main sector spans 2^MAIN_SZ_LOG2 bytes and each boot sector spans 2^BOOT_SZ_LOG2 bytes. A sector matches only when it is enabled and the address bits above its size equal its base field. By default these are address[15:12] for main sectors and address[15:6] for boot sectors.
- R4: A program-space sector can be selected only while `psen_n` is low. A data-space sector can be selected only while `rd_n` or `wr_n` is low.
- R5: Selects are registered. A strobe sampled at a rising edge affects the selects visible after that edge. When no strobe is low, all selects are low after the next edge.
- R6: When several sectors match, only the lowest-numbered matching main sector is selected. Any main match suppresses every boot select.
- R7: A write to a selected sector whose write-protect bit is set still raises that sector's select. Both array write strobes stay high.
- R8: A write to a selected unprotected sector drives only that array's write strobe (`main_wr_n` or `boot_wr_n`) low, registered like the selects. The other array's strobe stays high.
- R9: A blocked write sets `wp_viol`, which stays set until software writes a 1 to status bit 0. Writing a 0 to that bit has no effect. If a set and a clear occur in the same cycle, the set wins.
- R10: The register map is as follows. Address k (k < N_MAIN) holds main sector k. Address N_MAIN+j holds boot sector j. Address N_MAIN+N_BOOT holds status. In a sector register, bit 0 is enable, bit 1 selects program space (1) or data space (0), bit 2 is write protect, and bits [15:SZ_LOG2] hold the base. `cfg_rdata` returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ale | input | 1 | Address latch strobe, high while `ad_lo` carries the address |
| ad_lo | input | 8 | Multiplexed low address / data byte |
| a_hi | input | 8 | High address byte |
| psen_n | input | 1 | Program fetch strobe, active low |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | CFG_AW | Register address |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| main_sel | output | N_MAIN | One select per main sector, active high |
| boot_sel | output | N_BOOT | One select per boot sector, active high |
| main_wr_n | output | 1 | Write strobe to the main array, active low |
| boot_wr_n | output | 1 | Write strobe to the boot array, active low |
| wp_viol | output | 1 | Sticky blocked-write flag |

## Verification
A corrupted captured address byte shows up one edge after the strobe. It either moves a boot select to a neighbouring sector or drops a select that should have fired. A wrong enable, space bit or base shows in two places: in the register readback at once, and in the selects one edge after the next matching strobe. A wrong write-protect bit shows on the same edge as a write strobe leaking to an array, or as a violation flag that rose without cause. Random addresses are biased toward the programmed bases, so overlapping sectors and priority decisions come up often.

// File: rtl/fsd_pkg.sv
package fsd_pkg;
   localparam int ADDR_W   = 16;
   localparam int REG_W    = 16;
   localparam int FLD_EN   = 0;
   localparam int FLD_PROG = 1;
   localparam int FLD_WP   = 2;
   localparam int FLAG_W   = 3;
   localparam logic [REG_W-1:0] SECTOR_RESET = 16'h0004;
endpackage

// File: rtl/fsd_addr_latch.sv
module fsd_addr_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ale,
   input  logic [W-1:0] bus_in,
   output logic [W-1:0] lat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   lat_q <= '0;
      else if (ale) lat_q <= bus_in;
   end
endmodule

// File: rtl/fsd_sector_bank.sv
module fsd_sector_bank
   import fsd_pkg::*;
#(
   parameter int N       = 8,
   parameter int SZ_LOG2 = 12,
   localparam int BW     = ADDR_W - SZ_LOG2,
   localparam int IW     = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IW-1:0]     cfg_idx,
   input  logic [BW-1:0]     cfg_base,
   input  logic [FLAG_W-1:0] cfg_flags,
   input  logic [BW-1:0]     addr_hi,
   input  logic              psen_act,
   input  logic              data_act,
   output logic [N-1:0]      win,
   output logic              any_hit,
   output logic              win_wp,
   output logic [REG_W-1:0]  rd_word
);
   logic [BW-1:0] base_r [N];
   logic [N-1:0]  en_r, prog_r, wp_r, match;

   for (genvar g = 0; g < N; g++) begin : g_sector
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            base_r[g] <= '0;
            en_r[g]   <= 1'b0;
            prog_r[g] <= 1'b0;
            wp_r[g]   <= 1'b1;
         end else if (cfg_we && (int'(cfg_idx) == g)) begin
            base_r[g] <= cfg_base;
            en_r[g]   <= cfg_flags[FLD_EN];
            prog_r[g] <= cfg_flags[FLD_PROG];
            wp_r[g]   <= cfg_flags[FLD_WP];
         end
      end
      assign match[g] = en_r[g] && (addr_hi == base_r[g]) &&
                        (prog_r[g] ? psen_act : data_act);
   end

   always_comb begin
      win    = '0;
      win_wp = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (match[i]) begin
            win    = '0;
            win[i] = 1'b1;
            win_wp = wp_r[i];
         end
      end
   end
   assign any_hit = |match;

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < N; i++) begin
         if (int'(cfg_idx) == i) begin
            rd_word[ADDR_W-1:SZ_LOG2] = base_r[i];
            rd_word[FLD_EN]           = en_r[i];
            rd_word[FLD_PROG]         = prog_r[i];
            rd_word[FLD_WP]           = wp_r[i];
         end
      end
   end
endmodule

// File: rtl/flash_sector_decoder.sv
module flash_sector_decoder
   import fsd_pkg::*;
#(
   parameter int N_MAIN       = 8,
   parameter int MAIN_SZ_LOG2 = 12,
   parameter int N_BOOT       = 4,
   parameter int BOOT_SZ_LOG2 = 6,
   localparam int N_REGS      = N_MAIN + N_BOOT + 1,
   localparam int CFG_AW      = $clog2(N_REGS),
   localparam int STAT_IDX    = N_MAIN + N_BOOT,
   localparam int MIW         = (N_MAIN > 1) ? $clog2(N_MAIN) : 1,
   localparam int BIW         = (N_BOOT > 1) ? $clog2(N_BOOT) : 1,
   localparam int MBW         = ADDR_W - MAIN_SZ_LOG2,
   localparam int BBW         = ADDR_W - BOOT_SZ_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ale,
   input  logic [7:0]        ad_lo,
   input  logic [7:0]        a_hi,
   input  logic              psen_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [REG_W-1:0]  cfg_wdata,
   output logic [REG_W-1:0]  cfg_rdata,
   output logic [N_MAIN-1:0] main_sel,
   output logic [N_BOOT-1:0] boot_sel,
   output logic              main_wr_n,
   output logic              boot_wr_n,
   output logic              wp_viol
);
   if (N_MAIN < 1 || N_BOOT < 1) begin : g_bad_count
      $error("flash_sector_decoder: each array needs at least one sector");
   end
   if (MAIN_SZ_LOG2 < FLAG_W || MAIN_SZ_LOG2 > ADDR_W - 1 ||
       BOOT_SZ_LOG2 < FLAG_W || BOOT_SZ_LOG2 > ADDR_W - 1) begin : g_bad_size
      $error("flash_sector_decoder: sector size leaves no room for flags or base");
   end
   if ((N_MAIN << MAIN_SZ_LOG2) > (1 << ADDR_W)) begin : g_bad_span
      $error("flash_sector_decoder: main array larger than address space");
   end

   logic [7:0]        lo_q;
   logic [ADDR_W-1:0] addr;
   logic              psen_act, data_act, wr_act;

   fsd_addr_latch #(.W(8)) i_lat (
      .clk(clk), .rst_n(rst_n), .ale(ale), .bus_in(ad_lo), .lat_q(lo_q)
   );

   assign addr     = {a_hi, lo_q};
   assign psen_act = ~psen_n;
   assign wr_act   = ~wr_n;
   assign data_act = ~rd_n | wr_act;

   // register file decode
   logic           m_we, b_we, stat_hit;
   logic [MIW-1:0] m_idx;
   logic [BIW-1:0] b_idx;
   int             b_off;

   assign stat_hit = (int'(cfg_addr) == STAT_IDX);
   assign m_we     = cfg_we && (int'(cfg_addr) < N_MAIN);
   assign b_we     = cfg_we && (int'(cfg_addr) >= N_MAIN) && (int'(cfg_addr) < STAT_IDX);
   assign m_idx    = MIW'(cfg_addr);
   assign b_off    = int'(cfg_addr) - N_MAIN;
   assign b_idx    = BIW'(b_off);

   logic [N_MAIN-1:0] m_win;
   logic [N_BOOT-1:0] b_win;
   logic              m_any, b_any, m_wp, b_wp;
   logic [REG_W-1:0]  m_rd, b_rd;

   fsd_sector_bank #(.N(N_MAIN), .SZ_LOG2(MAIN_SZ_LOG2)) i_main (
      .clk(clk), .rst_n(rst_n), .cfg_we(m_we), .cfg_idx(m_idx),
      .cfg_base(cfg_wdata[ADDR_W-1:MAIN_SZ_LOG2]), .cfg_flags(cfg_wdata[FLAG_W-1:0]),
      .addr_hi(addr[ADDR_W-1:MAIN_SZ_LOG2]), .psen_act(psen_act), .data_act(data_act),
      .win(m_win), .any_hit(m_any), .win_wp(m_wp), .rd_word(m_rd)
   );

   fsd_sector_bank #(.N(N_BOOT), .SZ_LOG2(BOOT_SZ_LOG2)) i_boot (
      .clk(clk), .rst_n(rst_n), .cfg_we(b_we), .cfg_idx(b_idx),
      .cfg_base(cfg_wdata[ADDR_W-1:BOOT_SZ_LOG2]), .cfg_flags(cfg_wdata[FLAG_W-1:0]),
      .addr_hi(addr[ADDR_W-1:BOOT_SZ_LOG2]), .psen_act(psen_act), .data_act(data_act),
      .win(b_win), .any_hit(b_any), .win_wp(b_wp), .rd_word(b_rd)
   );

   // main array outranks boot array
   logic [N_BOOT-1:0] b_sel_d;
   logic              m_wr_d, b_wr_d, viol_set, viol_clr;

   assign b_sel_d  = m_any ? '0 : b_win;
   assign m_wr_d   = wr_act && m_any && !m_wp;
   assign b_wr_d   = wr_act && !m_any && b_any && !b_wp;
   assign viol_set = wr_act && (m_any ? m_wp : (b_any && b_wp));
   assign viol_clr = cfg_we && stat_hit && cfg_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_sel  <= '0;
         boot_sel  <= '0;
         main_wr_n <= 1'b1;
         boot_wr_n <= 1'b1;
         wp_viol   <= 1'b0;
      end else begin
         main_sel  <= m_win;
         boot_sel  <= b_sel_d;
         main_wr_n <= ~m_wr_d;
         boot_wr_n <= ~b_wr_d;
         if (viol_set)      wp_viol <= 1'b1;
         else if (viol_clr) wp_viol <= 1'b0;
      end
   end

   always_comb begin
      if (int'(cfg_addr) < N_MAIN)        cfg_rdata = m_rd;
      else if (int'(cfg_addr) < STAT_IDX) cfg_rdata = b_rd;
      else if (stat_hit)                  cfg_rdata = {{(REG_W-1){1'b0}}, wp_viol};
      else                                cfg_rdata = '0;
   end

   logic unused_ok;
   assign unused_ok = ^{cfg_wdata, addr};
endmodule

// File: rtl/fsd_checker.sv
module fsd_checker #(
   parameter int N_MAIN   = 8,
   parameter int N_BOOT   = 4,
   parameter int CFG_AW   = 4,
   parameter int STAT_IDX = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psen_n,
   input logic              rd_n,
   input logic              wr_n,
   input logic              cfg_we,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [15:0]       cfg_wdata,
   input logic [N_MAIN-1:0] main_sel,
   input logic [N_BOOT-1:0] boot_sel,
   input logic              main_wr_n,
   input logic              boot_wr_n,
   input logic              wp_viol
);
   logic clr_req;
   assign clr_req = cfg_we && (int'(cfg_addr) == STAT_IDX) && cfg_wdata[0];

   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({main_sel, boot_sel})); // R6
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (psen_n && rd_n && wr_n) |=> (main_sel == '0 && boot_sel == '0)); // R5
   AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rst_n)
      wr_n |=> (main_wr_n && boot_wr_n)); // R7
   AST_WR_ONE_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
      !(!main_wr_n && !boot_wr_n)); // R8
   AST_MAIN_WR_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !main_wr_n |-> (|main_sel)); // R8
   AST_BOOT_WR_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_wr_n |-> (|boot_sel)); // R8
   AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_viol && !clr_req) |=> wp_viol); // R9
   AST_VIOL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wp_viol) |-> $past(!wr_n)); // R7
endmodule

bind flash_sector_decoder fsd_checker #(
   .N_MAIN(N_MAIN), .N_BOOT(N_BOOT), .CFG_AW(CFG_AW), .STAT_IDX(STAT_IDX)
) i_fsd_chk (
   .clk(clk), .rst_n(rst_n), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
   .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
   .main_sel(main_sel), .boot_sel(boot_sel), .main_wr_n(main_wr_n),
   .boot_wr_n(boot_wr_n), .wp_viol(wp_viol)
);

// File: tb/test_flash_sector_decoder.sv
`timescale 1ns/1ps
module test_flash_sector_decoder;
   localparam int NM = 8, NB = 4, MS = 12, BS = 6, STAT = NM + NB, AW = 4;
   localparam int K_PSEN = 0, K_RD = 1, K_WR = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ale = 1'b0, psen_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, cfg_we = 1'b0;
   logic [7:0] ad_lo = '0, a_hi = '0;
   logic [AW-1:0] cfg_addr = '0;
   logic [15:0] cfg_wdata = '0, cfg_rdata;
   logic [NM-1:0] main_sel;
   logic [NB-1:0] boot_sel;
   logic main_wr_n, boot_wr_n, wp_viol;

   flash_sector_decoder i_flash_sector_decoder (
      .clk(clk), .rst_n(rst_n), .ale(ale), .ad_lo(ad_lo), .a_hi(a_hi),
      .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .main_sel(main_sel), .boot_sel(boot_sel), .main_wr_n(main_wr_n),
      .boot_wr_n(boot_wr_n), .wp_viol(wp_viol)
   );

   always #2.5 clk = ~clk;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // bench model
   bit m_en[NM], m_pg[NM], m_wp[NM], b_en[NB], b_pg[NB], b_wp[NB];
   logic [15-MS:0] m_base[NM];
   logic [15-BS:0] b_base[NB];
   logic e_viol = 1'b0;
   logic [NM-1:0] e_m;
   logic [NB-1:0] e_b;
   logic e_mwr, e_bwr, e_vset;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic set_main(input int i, input bit en, input bit pg, input bit wp, input logic [15-MS:0] b);
      m_en[i] = en; m_pg[i] = pg; m_wp[i] = wp; m_base[i] = b;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(i);
      cfg_wdata = {b, {(MS-3){1'b0}}, wp, pg, en};
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_boot(input int j, input bit en, input bit pg, input bit wp, input logic [15-BS:0] b);
      b_en[j] = en; b_pg[j] = pg; b_wp[j] = wp; b_base[j] = b;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(NM + j);
      cfg_wdata = {b, {(BS-3){1'b0}}, wp, pg, en};
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic write_stat(input bit v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(STAT); cfg_wdata = {15'd0, v};
      @(negedge clk);
      cfg_we = 1'b0;
      if (v) e_viol = 1'b0;
   endtask

   task automatic compute(input logic [15:0] a, input int kind);
      bit hit = 1'b0, wpw = 1'b0, in_main = 1'b0;
      e_m = '0; e_b = '0;
      for (int i = 0; i < NM; i++)
         if (!hit && m_en[i] && a[15:MS] == m_base[i] && (m_pg[i] == (kind == K_PSEN))) begin
            e_m[i] = 1'b1; hit = 1'b1; wpw = m_wp[i]; in_main = 1'b1;
         end
      for (int j = 0; j < NB; j++)
         if (!hit && b_en[j] && a[15:BS] == b_base[j] && (b_pg[j] == (kind == K_PSEN))) begin
            e_b[j] = 1'b1; hit = 1'b1; wpw = b_wp[j];
         end
      e_mwr  = !(kind == K_WR && hit && in_main && !wpw);
      e_bwr  = !(kind == K_WR && hit && !in_main && !wpw);
      e_vset = (kind == K_WR && hit && wpw);
   endtask

   task automatic access(input logic [15:0] a, input logic [7:0] junk, input int kind,
                         input bit clr_same, input string req);
      @(negedge clk);
      ale = 1'b1; ad_lo = a[7:0]; a_hi = a[15:8];
      @(negedge clk);
      ale = 1'b0; ad_lo = junk;
      psen_n = (kind != K_PSEN); rd_n = (kind != K_RD); wr_n = (kind != K_WR);
      if (clr_same) begin
         cfg_we = 1'b1; cfg_addr = AW'(STAT); cfg_wdata = 16'h0001;
      end
      compute(a, kind);
      @(negedge clk);
      e_viol = e_vset ? 1'b1 : (clr_same ? 1'b0 : e_viol);
      chk({req, " main_sel"}, 32'(main_sel), 32'(e_m));
      chk({req, " boot_sel"}, 32'(boot_sel), 32'(e_b));
      chk({req, " R8 main_wr_n"}, 32'(main_wr_n), 32'(e_mwr));
      chk({req, " R8 boot_wr_n"}, 32'(boot_wr_n), 32'(e_bwr));
      chk({req, " R9 wp_viol"}, 32'(wp_viol), 32'(e_viol));
      psen_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; cfg_we = 1'b0;
      @(negedge clk);
      chk("R5 idle selects", 32'({main_sel, boot_sel}), 32'd0);
      chk("R5 idle write strobes", 32'({main_wr_n, boot_wr_n}), 32'd3);
      chk("R9 idle wp_viol", 32'(wp_viol), 32'(e_viol));
   endtask

   task automatic rd_chk(input int a, input logic [15:0] exp, input string req);
      cfg_addr = AW'(a);
      #1;
      chk(req, 32'(cfg_rdata), 32'(exp));
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog (all) act=running exp=finished");
         summary();
      end
   end

   initial begin
      void'($urandom(32'd51877));
      for (int i = 0; i < NM; i++) begin m_en[i] = 0; m_pg[i] = 0; m_wp[i] = 1; m_base[i] = '0; end
      for (int j = 0; j < NB; j++) begin b_en[j] = 0; b_pg[j] = 0; b_wp[j] = 1; b_base[j] = '0; end

      // R2: values during and after reset
      repeat (3) @(negedge clk);
      chk("R2 sel in reset", 32'({main_sel, boot_sel}), 32'd0);
      chk("R2 wr_n in reset", 32'({main_wr_n, boot_wr_n}), 32'd3);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 viol after reset", 32'(wp_viol), 32'd0);
      for (int k = 0; k < NM + NB; k++) rd_chk(k, 16'h0004, "R2 R10 sector reset word");
      rd_chk(STAT, 16'h0000, "R2 status reset");
      access(16'h1234, 8'h00, K_RD, 1'b0, "R2 unmapped read");

      // R3: boundaries of main sector 0 at 0x1000..0x1FFF, data space
      set_main(0, 1, 0, 0, 4'h1);
      rd_chk(0, 16'h1001, "R10 main readback");
      access(16'h1000, 8'hAA, K_RD, 1'b0, "R3 low edge");
      access(16'h1FFF, 8'h00, K_RD, 1'b0, "R3 high edge");
      access(16'h2000, 8'h00, K_RD, 1'b0, "R3 above");
      access(16'h0FFF, 8'h00, K_RD, 1'b0, "R3 below");

      // R4: program-space sector only on PSEN
      set_main(1, 1, 1, 0, 4'h3);
      access(16'h3456, 8'h11, K_RD, 1'b0, "R4 prog sector on RD");
      access(16'h3456, 8'h11, K_PSEN, 1'b0, "R4 prog sector on PSEN");
      access(16'h1456, 8'h11, K_PSEN, 1'b0, "R4 data sector on PSEN");

      // R1: boot sector 0x0040..0x007F, junk on ad_lo after capture
      set_boot(0, 1, 0, 0, 10'h001);
      rd_chk(NM, 16'h0041, "R10 boot readback");
      access(16'h0040, 8'h00, K_RD, 1'b0, "R1 junk below");
      access(16'h0080, 8'h40, K_RD, 1'b0, "R1 junk inside");

      // R6: priority
      set_main(3, 1, 0, 0, 4'h1);
      access(16'h1800, 8'h00, K_RD, 1'b0, "R6 lowest main");
      set_main(2, 1, 0, 0, 4'h0);
      access(16'h0050, 8'h00, K_RD, 1'b0, "R6 main over boot");
      set_main(2, 0, 0, 0, 4'h0);
      access(16'h0050, 8'h00, K_RD, 1'b0, "R6 boot after main disabled");

      // R8: unprotected writes hit only their array
      access(16'h1100, 8'h5A, K_WR, 1'b0, "R8 main write");
      access(16'h0060, 8'h5A, K_WR, 1'b0, "R8 boot write");

      // R7 / R9: protected writes, sticky flag, write-one-to-clear
      set_boot(1, 1, 0, 1, 10'h002);
      access(16'h0090, 8'hC3, K_WR, 1'b0, "R7 protected boot write");
      access(16'h0090, 8'h00, K_RD, 1'b0, "R9 read keeps flag");
      write_stat(1'b0);
      chk("R9 write zero ignored", 32'(wp_viol), 32'd1);
      rd_chk(STAT, 16'h0001, "R9 R10 status readback");
      write_stat(1'b1);
      chk("R9 write one clears", 32'(wp_viol), 32'd0);
      set_main(0, 1, 0, 1, 4'h1);
      access(16'h1010, 8'h00, K_WR, 1'b0, "R7 protected main write");
      access(16'h1010, 8'h00, K_WR, 1'b1, "R9 set beats clear");
      access(16'h1010, 8'h00, K_RD, 1'b1, "R9 clear alone");

      // random phase
      for (int it = 0; it < 400; it++) begin
         logic [15:0] a;
         int pick, kind;
         if (it % 50 == 0) begin
            for (int i = 0; i < NM; i++)
               set_main(i, ($urandom % 4) != 0, $urandom % 2, $urandom % 2, 4'($urandom));
            for (int j = 0; j < NB; j++)
               set_boot(j, ($urandom % 4) != 0, $urandom % 2, $urandom % 2, 10'($urandom % 16));
            for (int i = 0; i < NM; i++)
               rd_chk(i, {m_base[i], 9'd0, m_wp[i], m_pg[i], m_en[i]}, "R10 random main readback");
         end
         pick = $urandom % 3;
         a = 16'($urandom);
         if (pick == 1) a[15:MS] = m_base[$urandom % NM];
         else if (pick == 2) a[15:BS] = b_base[$urandom % NB];
         kind = $urandom % 3;
         access(a, 8'($urandom), kind, ($urandom % 8) == 0, "R3 R4 R6 random");
      end

      done = 1'b1;
      summary();
   end
endmodule